// File: doc/BRIEF.md
# SPI Framed Register Access Controller

This block is a serial-peripheral slave that services fixed 16-bit frames aimed at one interrupt-enable register. The most significant bits of each frame carry a two-bit register address, a read-select flag and a read-only flag. The low twelve bits carry the value that may be written. In the same frame, the slave shifts back either the interrupt status word supplied by the rest of the chip or the stored enable bits. It commits a write only when chip select is released.

The SPI pins are sampled into the system clock domain through synchronizers, and all frame logic runs on `clk_i`. Each frame must contain exactly sixteen SCK cycles. With any other count, the frame is discarded. If the SPI-failure enable bit is set, a bad count also produces a one-cycle failure interrupt pulse. While the chip is in its start-up or restart phase, a one-cycle reset request pulse is produced instead of the interrupt.

Top module: `spi_frame_regs`

## Requirements
- R1: A frame with exactly 16 SCK rising edges, address bits [15:14] = 01 and bit 12 = 0 writes frame bits [11:0] into `int_en_o`. The new value is visible within a few clocks of chip select rising.
- R2: A 16-clock frame to address 01 with bit 12 = 1 leaves `int_en_o` unchanged.
- R3: A frame whose address is not 01 leaves `int_en_o` unchanged, and every bit it shifts out is zero.
- R4: MISO returns 16 bits MSB first: the first four bits are zero, followed by twelve data bits. MOSI is sampled on SCK rising edges and MISO changes on SCK falling edges. When bit 13 = 1, the data bits are `int_stat_i`. When bit 13 = 0, they are the enable bits stored before the frame.
- R5: A frame with fewer than 16 SCK cycles, including zero, writes nothing.
- R6: A frame with more than 16 SCK cycles writes nothing.
- R7: A clock-count error while enable bit 8 is set and `boot_mode_i` is low gives exactly one `spi_fail_irq_o` pulse and no reset request.
- R8: A clock-count error while enable bit 8 is set and `boot_mode_i` is high gives exactly one `reset_req_o` pulse and no interrupt.
- R9: A clock-count error while enable bit 8 is clear raises neither output.
- R10: Reset clears `int_en_o` and drives `miso_o`, `spi_fail_irq_o` and `reset_req_o` low.
- R11: SCK edges while chip select is high have no effect on the registers or on the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | SPI serial clock |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| boot_mode_i | input | 1 | High during start-up or restart phase |
| int_stat_i | input | 12 | Interrupt status word to be read back |
| int_en_o | output | 12 | Stored interrupt enable bits |
| spi_fail_irq_o | output | 1 | One-cycle pulse on a clock-count error |
| reset_req_o | output | 1 | One-cycle reset request on a clock-count error in boot mode |

## Verification
Frames are run with 0, 3, 8, 15, 16, 17 and 20 SCK cycles. This tells exact-count acceptance apart from both short and saturating long counts, and the partial read-back shows how far the shifter progressed. The sixteen-clock frames vary the address, read-select and read-only bits independently, so that a write leak or a wrong read source shows up on its own. Error frames are repeated with the failure-enable bit set and cleared and with `boot_mode_i` high and low, which separates the interrupt path from the reset-request path and from silence.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int FRAME_W  = 16;
  localparam int ADDR_W   = 2;
  localparam int HDR_BITS = ADDR_W + 2;
  localparam int DATA_W   = FRAME_W - HDR_BITS;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam logic [ADDR_W-1:0] IEN_ADDR = 2'b01;
  localparam int SPIF_BIT = 8;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[0] <= RST_VAL;
        else         st_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st_q[g] <= RST_VAL;
        else         st_q[g] <= st_q[g-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift
  import spi_frame_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_s_i,
  input  logic          csn_s_i,
  input  logic          mosi_s_i,
  input  logic [DW-1:0] rd_word_i,
  output logic [AW-1:0] hdr_addr_o,
  output logic          hdr_rsel_o,
  output logic          miso_o,
  output logic          done_o,
  output logic          cnt_ok_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          wr_ro_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int HB = FW - DW;

  logic          sck_q, csn_q;
  logic          sck_rise, sck_fall, cs_fall, cs_rise, active;
  logic [FW-1:0] rx_q;
  logic [DW-1:0] tx_q;
  logic [CW-1:0] cnt_q;
  logic          miso_q;
  logic          load_hdr, tx_phase;

  assign sck_rise = sck_s_i & ~sck_q;
  assign sck_fall = ~sck_s_i & sck_q;
  assign cs_fall  = csn_q & ~csn_s_i;
  assign cs_rise  = ~csn_q & csn_s_i;
  assign active   = ~csn_s_i;

  // read source is known on the rising edge that samples the read-select bit
  assign load_hdr = cnt_q == CW'(HB - 2);
  assign tx_phase = (cnt_q >= CW'(HB)) && (cnt_q <= CW'(FW - 1));

  assign hdr_addr_o = rx_q[AW-1:0];
  assign hdr_rsel_o = mosi_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      csn_q  <= 1'b1;
      rx_q   <= '0;
      tx_q   <= '0;
      cnt_q  <= '0;
      miso_q <= 1'b0;
    end else begin
      sck_q <= sck_s_i;
      csn_q <= csn_s_i;
      if (cs_fall) begin
        rx_q   <= '0;
        tx_q   <= '0;
        cnt_q  <= '0;
        miso_q <= 1'b0;
      end else if (cs_rise) begin
        miso_q <= 1'b0;
      end else if (active && sck_rise) begin
        rx_q <= {rx_q[FW-2:0], mosi_s_i};
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        if (load_hdr) tx_q <= rd_word_i;
      end else if (active && sck_fall) begin
        if (tx_phase) begin
          miso_q <= tx_q[DW-1];
          tx_q   <= {tx_q[DW-2:0], 1'b0};
        end else begin
          miso_q <= 1'b0;
        end
      end
    end
  end

  assign miso_o    = miso_q;
  assign done_o    = cs_rise;
  assign cnt_ok_o  = cnt_q == CW'(FW);
  assign wr_addr_o = rx_q[FW-1 -: AW];
  assign wr_ro_o   = rx_q[DW];
  assign wr_data_o = rx_q[DW-1:0];
endmodule

// File: rtl/spi_frame_bank.sv
module spi_frame_bank
  import spi_frame_pkg::*;
#(
  parameter int              AW       = ADDR_W,
  parameter int              DW       = DATA_W,
  parameter logic [AW-1:0]   REG_ADDR = IEN_ADDR,
  parameter int              FAIL_BIT = SPIF_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          cnt_ok_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_ro_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] hdr_addr_i,
  input  logic          hdr_rsel_i,
  input  logic [DW-1:0] stat_i,
  input  logic          boot_mode_i,
  output logic [DW-1:0] rd_word_o,
  output logic [DW-1:0] ien_o,
  output logic          irq_o,
  output logic          rst_req_o
);
  logic [DW-1:0] ien_q;
  logic          irq_q, rst_q, bad_cnt;

  assign bad_cnt = done_i & ~cnt_ok_i & ien_q[FAIL_BIT];

  always_comb begin
    rd_word_o = '0;
    if (hdr_addr_i == REG_ADDR) rd_word_o = hdr_rsel_i ? stat_i : ien_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      if (done_i && cnt_ok_i && wr_addr_i == REG_ADDR && !wr_ro_i) ien_q <= wr_data_i;
      irq_q <= bad_cnt & ~boot_mode_i;
      rst_q <= bad_cnt & boot_mode_i;
    end
  end

  assign ien_o     = ien_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/spi_frame_regs.sv
module spi_frame_regs
  import spi_frame_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DW          = DATA_W,
  parameter int FAIL_BIT    = SPIF_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          csn_i,
  input  logic          mosi_i,
  output logic          miso_o,
  input  logic          boot_mode_i,
  input  logic [DW-1:0] int_stat_i,
  output logic [DW-1:0] int_en_o,
  output logic          spi_fail_irq_o,
  output logic          reset_req_o
);
  logic              sck_s, csn_s, mosi_s;
  logic [DW-1:0]     rd_word;
  logic [ADDR_W-1:0] hdr_addr, wr_addr;
  logic              hdr_rsel, wr_ro;
  logic [DW-1:0]     wr_data;
  logic              frame_done, cnt_ok;

  spi_pin_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({sck_i, csn_i, mosi_i}),
    .q_o({sck_s, csn_s, mosi_s})
  );

  spi_frame_shift #(.DW(DW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sck_s_i(sck_s), .csn_s_i(csn_s), .mosi_s_i(mosi_s),
    .rd_word_i(rd_word),
    .hdr_addr_o(hdr_addr), .hdr_rsel_o(hdr_rsel),
    .miso_o(miso_o), .done_o(frame_done), .cnt_ok_o(cnt_ok),
    .wr_addr_o(wr_addr), .wr_ro_o(wr_ro), .wr_data_o(wr_data)
  );

  spi_frame_bank #(.DW(DW), .FAIL_BIT(FAIL_BIT)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .done_i(frame_done), .cnt_ok_i(cnt_ok),
    .wr_addr_i(wr_addr), .wr_ro_i(wr_ro), .wr_data_i(wr_data),
    .hdr_addr_i(hdr_addr), .hdr_rsel_i(hdr_rsel),
    .stat_i(int_stat_i), .boot_mode_i(boot_mode_i),
    .rd_word_o(rd_word), .ien_o(int_en_o),
    .irq_o(spi_fail_irq_o), .rst_req_o(reset_req_o)
  );
endmodule

// File: rtl/spi_frame_regs_chk.sv
module spi_frame_regs_chk #(
  parameter int DW       = 12,
  parameter int FAIL_BIT = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          csn_s,
  input logic          frame_done,
  input logic          cnt_ok,
  input logic          boot_mode_i,
  input logic [DW-1:0] int_en_o,
  input logic          miso_o,
  input logic          spi_fail_irq_o,
  input logic          reset_req_o
);
  // R1
  en_write_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(int_en_o) |-> $past(frame_done && cnt_ok));

  // R7
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_fail_irq_o |-> $past(frame_done && !cnt_ok && int_en_o[FAIL_BIT] && !boot_mode_i));

  // R8
  rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(frame_done && !cnt_ok && int_en_o[FAIL_BIT] && boot_mode_i));

  // R9
  fail_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({spi_fail_irq_o, reset_req_o}) <= 1);

  // R4
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_s && $past(csn_s)) |-> !miso_o);
endmodule

bind spi_frame_regs spi_frame_regs_chk #(.DW(DW), .FAIL_BIT(FAIL_BIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_s(csn_s),
  .frame_done(frame_done), .cnt_ok(cnt_ok), .boot_mode_i(boot_mode_i),
  .int_en_o(int_en_o), .miso_o(miso_o),
  .spi_fail_irq_o(spi_fail_irq_o), .reset_req_o(reset_req_o)
);

// File: tb/tb_spi_frame_regs.sv
module tb_spi_frame_regs;
  localparam int HALF = 8;
  localparam int NV   = 13;

  typedef struct packed {
    logic [15:0] w;
    logic [4:0]  n;
    logic        boot;
    logic [11:0] stat;
    logic [11:0] ien;
    logic [15:0] rx;
    logic        irq;
    logic        rst;
  } vec_t;

  // R1 R2 R3 R4 R5 R6 R7 R8 R9 in sequence; ien carries over
  localparam vec_t VECS [NV] = '{
    '{16'h40A5, 5'd16, 1'b0, 12'h000, 12'h0A5, 16'h0000, 1'b0, 1'b0},
    '{16'h7FFF, 5'd16, 1'b0, 12'h3C6, 12'h0A5, 16'h03C6, 1'b0, 1'b0},
    '{16'h5123, 5'd16, 1'b0, 12'hFFF, 12'h0A5, 16'h00A5, 1'b0, 1'b0},
    '{16'h8777, 5'd16, 1'b0, 12'h555, 12'h0A5, 16'h0000, 1'b0, 1'b0},
    '{16'h2FFF, 5'd16, 1'b0, 12'h555, 12'h0A5, 16'h0000, 1'b0, 1'b0},
    '{16'h4FFF, 5'd15, 1'b0, 12'h000, 12'h0A5, 16'h00A4, 1'b0, 1'b0},
    '{16'h4FFF, 5'd17, 1'b1, 12'h000, 12'h0A5, 16'h00A5, 1'b0, 1'b0},
    '{16'h413C, 5'd16, 1'b0, 12'h000, 12'h13C, 16'h00A5, 1'b0, 1'b0},
    '{16'h4000, 5'd8,  1'b0, 12'h000, 12'h13C, 16'h0100, 1'b1, 1'b0},
    '{16'h4000, 5'd20, 1'b1, 12'h000, 12'h13C, 16'h013C, 1'b0, 1'b1},
    '{16'h4000, 5'd0,  1'b0, 12'h000, 12'h13C, 16'h0000, 1'b1, 1'b0},
    '{16'h4000, 5'd16, 1'b1, 12'h000, 12'h000, 16'h013C, 1'b0, 1'b0},
    '{16'h4FFF, 5'd3,  1'b1, 12'h000, 12'h000, 16'h0000, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck = 1'b0, csn = 1'b1, mosi = 1'b0, boot = 1'b0;
  logic [11:0] stat = '0;
  logic        miso, irq, rreq;
  logic [11:0] ien;
  int          total = 0, fails = 0, irq_cnt = 0, rst_cnt = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  spi_frame_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .boot_mode_i(boot), .int_stat_i(stat), .int_en_o(ien),
    .spi_fail_irq_o(irq), .reset_req_o(rreq)
  );

  always @(posedge clk) begin
    if (irq)  irq_cnt <= irq_cnt + 1;
    if (rreq) rst_cnt <= rst_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int n, output logic [15:0] rx);
    rx = '0;
    csn = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(HALF);
      if (i < 16) rx[15-i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(2 * HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] rx;
    int i0, r0;
    wait_clk(5);
    // R10
    chk("R10 ien in reset", ien, 0);
    chk("R10 miso in reset", miso, 0);
    rst_ni = 1'b1;
    wait_clk(5);
    chk("R10 irq after reset", irq | rreq, 0);

    for (int v = 0; v < NV; v++) begin
      stat = VECS[v].stat;
      boot = VECS[v].boot;
      i0 = irq_cnt;
      r0 = rst_cnt;
      frame(VECS[v].w, int'(VECS[v].n), rx);
      chk($sformatf("R1/R2/R3/R5/R6 ien vec%0d", v), ien, VECS[v].ien);
      chk($sformatf("R4/R3 readback vec%0d", v), rx, VECS[v].rx);
      chk($sformatf("R7/R9 irq pulses vec%0d", v), irq_cnt - i0, VECS[v].irq);
      chk($sformatf("R8/R9 reset pulses vec%0d", v), rst_cnt - r0, VECS[v].rst);
    end

    // R11: SCK toggling with chip select high
    boot = 1'b0;
    i0 = irq_cnt;
    for (int k = 0; k < 5; k++) begin
      mosi = k[0];
      sck = 1'b1; wait_clk(HALF);
      sck = 1'b0; wait_clk(HALF);
    end
    chk("R11 ien after idle sck", ien, 12'h000);
    frame(16'h4155, 16, rx);
    chk("R11 write after idle sck", ien, 12'h155);
    chk("R11 readback after idle sck", rx, 16'h0000);
    chk("R11 no irq", irq_cnt - i0, 0);

    // R10: reset mid-operation
    csn = 1'b0;
    wait_clk(HALF);
    rst_ni = 1'b0;
    wait_clk(3);
    chk("R10 ien cleared", ien, 0);
    chk("R10 miso low", miso, 0);
    csn = 1'b1;
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(5);
    chk("R10 pulses low", irq | rreq, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule